// File: doc/BRIEF.md
# Fault-Tolerant Multistage Route Resolver

This block works out a path through a 16-port, four-stage irregular shuffle-exchange fabric for one request at a time. A start strobe captures a source port, a destination port and a busy/fault map for every switch in every stage. The resolver then moves one stage per clock. At each stage it picks the first usable switch from a short, fixed candidate list and records that switch's index. It ends with a one-cycle completion pulse and a flag that says whether the request was dropped.

The fabric is split into two identical halves, and the top bit of the destination picks which half is used. The first stage has four candidates: a conjugate pair in the chosen half, then the matching pair in the other half. Each middle stage has two candidates. The final stage has a single candidate. When the source and destination ports are equal and the direct link is usable, the request skips the middle stages and goes straight from the first stage to the final stage. Only the routing decision is made here; no data moves through this block.

Top module: `mstage_route_resolver`

## Requirements
- R1: Let `h = dst[3]` and `r = src % 2`. The candidate first-stage switches, in order, are `4h+r`, `4h+r+2`, `4(1-h)+r` and `4(1-h)+r+2`. Bit i of `mask_s0` set to 1 marks first-stage switch i as unusable. With a clear map, `sel_s0` is the first candidate.
- R2: The first stage takes the first candidate in R1 order whose mask bit is 0. If all four are masked, the request is dropped and `hop_valid` reads 0.
- R3: The bypass is taken when `src == dst` and the primary candidate c0 is clear in both `mask_s0` and `mask_last`. In that case `sel_s0 = sel_last = c0`, `hop_valid = 4'b1001`, `sel_mid` stays 0, and done rises two clocks after the accepting edge. Otherwise the normal walk is used.
- R4: For the first middle stage (mask bits `mask_mid[3:0]`), the stage-0 switch j gives group `q = j/4`. The primary is `2q + dst[0]` and the alternate is `2q + (1 - dst[0])`. If both are masked, the request drops.
- R5: For the second middle stage (mask bits `mask_mid[7:4]`), the previous switch k gives primary `2(k/2) + dst[1]` and alternate `2(k/2) + (1 - dst[1])`. If both are masked, the request drops.
- R6: The single final-stage candidate is `base + dst[2]`. For an even second-middle switch k, `base = 2k+2`; for an odd one, `base = 2k-2`. If it is masked in `mask_last`, the request drops and `hop_valid[3]` stays 0.
- R7: `done` is a one-clock pulse. It comes 4 clocks after the accepting edge for a full walk or a final-stage drop, and s+1 clocks after it for a drop at stage s (0 to 2).
- R8: `busy` is high from the edge after a start is accepted until the edge that raises `done`. A start seen while `busy` is high is ignored. A start during the `done` cycle is accepted.
- R9: `hop_valid[s]` marks that stage s made a selection. `sel_mid` packs middle stage m at bits `[2m+1:2m]`. All results are cleared to 0 on an accepted start and are then held unchanged from `done` until the next accepted start.
- R10: After reset, `busy`, `done`, `dropped`, `hop_valid` and all selections are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; sampled when idle |
| src | input | 4 | Source port |
| dst | input | 4 | Destination port; the top bit selects the half |
| mask_s0 | input | 8 | First-stage unusable map |
| mask_mid | input | 8 | Middle-stage unusable maps, 4 bits per stage |
| mask_last | input | 8 | Final-stage unusable map |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| dropped | output | 1 | Request could not be routed |
| hop_valid | output | 4 | Per-stage selection made |
| sel_s0 | output | 3 | Chosen first-stage switch |
| sel_mid | output | 4 | Chosen middle-stage switches, packed |
| sel_last | output | 3 | Chosen final-stage switch |

## Verification
The accepting edge is the clock edge on which a start is taken. `busy` is due one clock after that edge. `done` is due 1, 2, 3 or 4 clocks after it, depending on where the walk ends or drops; a bypass takes 2 clocks. The bench counts those edges in a behavioural model and compares `busy` and `done` on every falling edge. It compares the selections, `hop_valid` and `dropped` on every falling edge where the model says the walk is over, which covers the `done` cycle and the idle hold after it. The masks are overwritten with all-ones right after each start, so the results must come from the captured maps.

// File: rtl/rr_pkg.sv
// Shared types for the route resolver: walk state encoding.
package rr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_MID   = 2'd2,
        ST_LAST  = 2'd3
    } rr_state_e;
endpackage

// File: rtl/rr_first_pick.sv
// First-stage selector. Builds the four ordered candidates from the source
// lane and the destination's half bit. Returns the first unmasked one and
// says whether the direct first-to-final link may be used.
// Assumes N_PORTS >= 16 and is a power of two.
module rr_first_pick #(
    parameter int N_PORTS = 16
) (
    input  logic [$clog2(N_PORTS)-1:0]   src,
    input  logic [$clog2(N_PORTS)-1:0]   dst,
    input  logic [N_PORTS/2-1:0]         mask_first,
    input  logic [N_PORTS/2-1:0]         mask_final,
    output logic [$clog2(N_PORTS/2)-1:0] sel,
    output logic                         found,
    output logic                         bypass
);
    localparam int ADDR_W = $clog2(N_PORTS);
    localparam int S0_W   = $clog2(N_PORTS/2);
    localparam int HALF   = N_PORTS/4;
    localparam int PAIR   = N_PORTS/8;
    localparam int LANE_W = (PAIR > 1) ? $clog2(PAIR) : 1;
    localparam int N_CAND = 4;

    logic            half_bit;
    logic [S0_W-1:0] cand [N_CAND];

    assign half_bit = dst[ADDR_W-1];

    // candidate g: 0/1 in the chosen half, 2/3 in the other; odd g is the conjugate
    for (genvar g = 0; g < N_CAND; g++) begin : g_cand
        localparam int OFS = (g % 2) * PAIR;
        localparam bit FLIP = (g >= 2);
        assign cand[g] = S0_W'((((half_bit ^ FLIP) != 1'b0) ? HALF : 0)
                               + int'(src[LANE_W-1:0]) + OFS);
    end

    // fixed-priority scan: lowest candidate number that is usable wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_CAND-1; i >= 0; i--) begin
            if (!mask_first[cand[i]]) begin
                found = 1'b1;
                sel   = cand[i];
            end
        end
    end

    // direct route allowed only for matching ports with both ends usable
    assign bypass = (src == dst) && !mask_first[cand[0]] && !mask_final[cand[0]];
endmodule

// File: rtl/rr_mid_pick.sv
// Middle-stage selector. Given the group of the previous switch and one
// destination steering bit, tries the steered switch and then its partner.
module rr_mid_pick #(
    parameter int N_PORTS = 16
) (
    input  logic [$clog2(N_PORTS/4)-2:0] group_idx,
    input  logic                         steer,
    input  logic [N_PORTS/4-1:0]         mask,
    output logic [$clog2(N_PORTS/4)-1:0] sel,
    output logic                         found
);
    localparam int MID_W = $clog2(N_PORTS/4);

    logic [MID_W-1:0] prim;
    logic [MID_W-1:0] alt;

    assign prim = {group_idx, steer};
    assign alt  = {group_idx, ~steer};

    // primary first, partner second, nothing otherwise
    always_comb begin
        found = !mask[prim] || !mask[alt];
        sel   = !mask[prim] ? prim : alt;
    end
endmodule

// File: rtl/rr_last_pick.sv
// Final-stage selector. Maps the last middle switch onto its pair of
// final-stage switches (even k -> 2k+2.., odd k -> 2k-2..). Picks one with
// the steering bit, or takes the captured first-stage switch on a bypass.
module rr_last_pick #(
    parameter int N_PORTS = 16
) (
    input  logic [$clog2(N_PORTS/4)-1:0] prev_mid,
    input  logic                         steer,
    input  logic                         bypass,
    input  logic [$clog2(N_PORTS/2)-1:0] bypass_idx,
    input  logic [N_PORTS/2-1:0]         mask,
    output logic [$clog2(N_PORTS/2)-1:0] sel,
    output logic                         ok
);
    localparam int MID_W = $clog2(N_PORTS/4);

    logic [MID_W-1:0] pair_idx;

    // pair number is base/2: k+1 for even k, k-1 for odd k
    assign pair_idx = prev_mid[0] ? (prev_mid - MID_W'(1)) : (prev_mid + MID_W'(1));

    // single candidate; usable or not
    always_comb begin
        sel = bypass ? bypass_idx : {pair_idx, steer};
        ok  = !mask[sel];
    end
endmodule

// File: rtl/mstage_route_resolver.sv
// Route resolver top. Captures one request and its fault maps on start, then
// walks first stage, each middle stage and the final stage, one per clock.
// Ends with a one-cycle done pulse. Results stay put until the next accepted
// start. Starts arriving while a walk is running are ignored.
// Assumes N_PORTS is a power of two, at least 16.
module mstage_route_resolver #(
    parameter int N_PORTS = 16
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   start,
    input  logic [$clog2(N_PORTS)-1:0]                             src,
    input  logic [$clog2(N_PORTS)-1:0]                             dst,
    input  logic [N_PORTS/2-1:0]                                   mask_s0,
    input  logic [($clog2(N_PORTS)-2)*(N_PORTS/4)-1:0]             mask_mid,
    input  logic [N_PORTS/2-1:0]                                   mask_last,
    output logic                                                   busy,
    output logic                                                   done,
    output logic                                                   dropped,
    output logic [$clog2(N_PORTS)-1:0]                             hop_valid,
    output logic [$clog2(N_PORTS/2)-1:0]                           sel_s0,
    output logic [($clog2(N_PORTS)-2)*$clog2(N_PORTS/4)-1:0]       sel_mid,
    output logic [$clog2(N_PORTS/2)-1:0]                           sel_last
);
    import rr_pkg::*;

    localparam int ADDR_W     = $clog2(N_PORTS);
    localparam int S0_CNT     = N_PORTS/2;
    localparam int MID_CNT    = N_PORTS/4;
    localparam int S0_W       = $clog2(S0_CNT);
    localparam int MID_W      = $clog2(MID_CNT);
    localparam int MID_STAGES = ADDR_W - 2;
    localparam int CTR_W      = $clog2(ADDR_W);

    rr_state_e                     state_q;
    logic [ADDR_W-1:0]             lat_src_q;
    logic [ADDR_W-1:0]             lat_dst_q;
    logic [S0_CNT-1:0]             lat_m0_q;
    logic [MID_STAGES*MID_CNT-1:0] lat_mid_q;
    logic [S0_CNT-1:0]             lat_ml_q;
    logic [CTR_W-1:0]              ctr_q;
    logic                          byp_q;
    logic [MID_W-1:0]              prev_mid_q;
    logic [S0_W-1:0]               sel_s0_q;
    logic [MID_STAGES*MID_W-1:0]   sel_mid_q;
    logic [S0_W-1:0]               sel_last_q;
    logic [ADDR_W-1:0]             hop_q;
    logic                          done_q;
    logic                          drop_q;

    logic [S0_W-1:0]  f_sel;
    logic             f_found;
    logic             f_bypass;
    logic [MID_W-2:0] m_group;
    logic [MID_W-1:0] m_sel;
    logic             m_found;
    logic [S0_W-1:0]  l_sel;
    logic             l_ok;

    rr_first_pick #(.N_PORTS(N_PORTS)) u_first (
        .src        (lat_src_q),
        .dst        (lat_dst_q),
        .mask_first (lat_m0_q),
        .mask_final (lat_ml_q),
        .sel        (f_sel),
        .found      (f_found),
        .bypass     (f_bypass)
    );

    // group for the current middle stage: from stage 0 it is j/4, later k/2
    assign m_group = (ctr_q == '0) ? sel_s0_q[S0_W-1:2] : prev_mid_q[MID_W-1:1];

    rr_mid_pick #(.N_PORTS(N_PORTS)) u_mid (
        .group_idx (m_group),
        .steer     (lat_dst_q[ctr_q]),
        .mask      (lat_mid_q[int'(ctr_q)*MID_CNT +: MID_CNT]),
        .sel       (m_sel),
        .found     (m_found)
    );

    rr_last_pick #(.N_PORTS(N_PORTS)) u_last (
        .prev_mid   (prev_mid_q),
        .steer      (lat_dst_q[ADDR_W-2]),
        .bypass     (byp_q),
        .bypass_idx (sel_s0_q),
        .mask       (lat_ml_q),
        .sel        (l_sel),
        .ok         (l_ok)
    );

    // walk sequencer: capture, step one stage per clock, finish with a pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_src_q  <= '0;
            lat_dst_q  <= '0;
            lat_m0_q   <= '0;
            lat_mid_q  <= '0;
            lat_ml_q   <= '0;
            ctr_q      <= '0;
            byp_q      <= 1'b0;
            prev_mid_q <= '0;
            sel_s0_q   <= '0;
            sel_mid_q  <= '0;
            sel_last_q <= '0;
            hop_q      <= '0;
            done_q     <= 1'b0;
            drop_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        lat_src_q  <= src;
                        lat_dst_q  <= dst;
                        lat_m0_q   <= mask_s0;
                        lat_mid_q  <= mask_mid;
                        lat_ml_q   <= mask_last;
                        ctr_q      <= '0;
                        byp_q      <= 1'b0;
                        prev_mid_q <= '0;
                        sel_s0_q   <= '0;
                        sel_mid_q  <= '0;
                        sel_last_q <= '0;
                        hop_q      <= '0;
                        drop_q     <= 1'b0;
                        state_q    <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (f_found) begin
                        sel_s0_q <= f_sel;
                        hop_q[0] <= 1'b1;
                        byp_q    <= f_bypass;
                        state_q  <= f_bypass ? ST_LAST : ST_MID;
                    end else begin
                        drop_q  <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_MID: begin
                    if (m_found) begin
                        sel_mid_q[int'(ctr_q)*MID_W +: MID_W] <= m_sel;
                        prev_mid_q          <= m_sel;
                        hop_q[ctr_q + 1'b1] <= 1'b1;
                        if (ctr_q == CTR_W'(MID_STAGES-1)) begin
                            state_q <= ST_LAST;
                        end else begin
                            ctr_q <= ctr_q + 1'b1;
                        end
                    end else begin
                        drop_q  <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_LAST: begin
                    if (l_ok) begin
                        sel_last_q        <= l_sel;
                        hop_q[ADDR_W-1]   <= 1'b1;
                    end else begin
                        drop_q <= 1'b1;
                    end
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs come straight from the held registers
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign dropped   = drop_q;
    assign hop_valid = hop_q;
    assign sel_s0    = sel_s0_q;
    assign sel_mid   = sel_mid_q;
    assign sel_last  = sel_last_q;
endmodule

// File: rtl/rr_route_checker.sv
// Protocol and consistency properties for the route resolver. Bound to the
// top so that it can see the captured fault maps and source.
module rr_route_checker #(
    parameter int N_PORTS = 16
) (
    input logic                                             clk,
    input logic                                             rst_n,
    input logic                                             start,
    input logic                                             busy,
    input logic                                             done,
    input logic                                             dropped,
    input logic [$clog2(N_PORTS)-1:0]                       hop_valid,
    input logic [$clog2(N_PORTS/2)-1:0]                     sel_s0,
    input logic [($clog2(N_PORTS)-2)*$clog2(N_PORTS/4)-1:0] sel_mid,
    input logic [$clog2(N_PORTS/2)-1:0]                     sel_last,
    input logic [$clog2(N_PORTS)-1:0]                       lat_src,
    input logic [N_PORTS/2-1:0]                             lat_m0,
    input logic [N_PORTS/2-1:0]                             lat_ml
);
    localparam int TOP = $clog2(N_PORTS) - 1;

    // R7: completion lasts exactly one clock
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the walk is over when done shows
    p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start during a walk does not recapture the request
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lat_src));

    // R9: idle without a start leaves every result untouched
    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sel_s0) && $stable(sel_mid) &&
                               $stable(sel_last) && $stable(hop_valid) &&
                               $stable(dropped)));

    // R2 / R6: a delivered route uses only usable end switches
    p_route_usable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dropped) |-> (!lat_m0[sel_s0] && !lat_ml[sel_last]));

    // R6: a dropped request never claims a final-stage switch
    p_drop_no_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dropped) |-> !hop_valid[TOP]);

    // R3: a delivered route without middle hops links the same switch index
    p_bypass_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dropped && !hop_valid[1]) |-> (sel_last == sel_s0));
endmodule

bind mstage_route_resolver rr_route_checker #(.N_PORTS(N_PORTS)) u_route_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .dropped   (dropped),
    .hop_valid (hop_valid),
    .sel_s0    (sel_s0),
    .sel_mid   (sel_mid),
    .sel_last  (sel_last),
    .lat_src   (lat_src_q),
    .lat_m0    (lat_m0_q),
    .lat_ml    (lat_ml_q)
);

// File: tb/tb_mstage_route_resolver.sv
// Bench for the route resolver: behavioural reference model stepped on each
// rising edge, compared with the design on each falling edge.
module tb_mstage_route_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] src = '0;
    logic [3:0] dst = '0;
    logic [7:0] mask_s0 = '0;
    logic [7:0] mask_mid = '0;
    logic [7:0] mask_last = '0;
    logic       busy, done, dropped;
    logic [3:0] hop_valid;
    logic [2:0] sel_s0;
    logic [3:0] sel_mid;
    logic [2:0] sel_last;

    mstage_route_resolver #(.N_PORTS(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src(src), .dst(dst),
        .mask_s0(mask_s0), .mask_mid(mask_mid), .mask_last(mask_last),
        .busy(busy), .done(done), .dropped(dropped), .hop_valid(hop_valid),
        .sel_s0(sel_s0), .sel_mid(sel_mid), .sel_last(sel_last)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R10";

    // reference model state
    bit e_busy = 0, e_done = 0, e_drop = 0, seen = 0;
    int e_hv = 0, e_s0 = 0, e_m0 = 0, e_m1 = 0, e_last = 0, left = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // routing rules written from the requirements
    task automatic resolve(input int s, input int d, input int a0, input int am, input int al,
                           output int hv, output int s0, output int mi0, output int mi1,
                           output int la, output bit drop, output int lat);
        int c[4];
        int h, k0, k1, k2, p, a, l, base;
        h = (d >> 3) & 1;
        c[0] = 4*h + s%2;       c[1] = c[0] + 2;
        c[2] = 4*(1-h) + s%2;   c[3] = c[2] + 2;
        hv = 0; s0 = 0; mi0 = 0; mi1 = 0; la = 0; drop = 0;
        if (s == d && ((a0 >> c[0]) & 1) == 0 && ((al >> c[0]) & 1) == 0) begin
            s0 = c[0]; la = c[0]; hv = 9; lat = 2;
            return;
        end
        k0 = -1;
        for (int i = 0; i < 4; i++)
            if (k0 < 0 && ((a0 >> c[i]) & 1) == 0) k0 = c[i];
        if (k0 < 0) begin drop = 1; lat = 1; return; end
        s0 = k0; hv = 1;
        p = 2*(k0/4) + (d & 1); a = 2*(k0/4) + 1 - (d & 1);
        if (((am >> p) & 1) == 0) k1 = p;
        else if (((am >> a) & 1) == 0) k1 = a;
        else begin drop = 1; lat = 2; return; end
        mi0 = k1; hv = 3;
        p = 2*(k1/2) + ((d >> 1) & 1); a = 2*(k1/2) + 1 - ((d >> 1) & 1);
        if (((am >> (4+p)) & 1) == 0) k2 = p;
        else if (((am >> (4+a)) & 1) == 0) k2 = a;
        else begin drop = 1; lat = 3; return; end
        mi1 = k2; hv = 7;
        base = (k2 % 2 == 0) ? 2*k2 + 2 : 2*k2 - 2;
        l = base + ((d >> 2) & 1);
        lat = 4;
        if (((al >> l) & 1) != 0) begin drop = 1; return; end
        la = l; hv = 15;
    endtask

    // model step on each rising edge
    always @(posedge clk) begin
        int hv, s0, mi0, mi1, la, lat;
        bit drop;
        seen = 1;
        if (!rst_n) begin
            e_busy = 0; e_done = 0; e_drop = 0;
            e_hv = 0; e_s0 = 0; e_m0 = 0; e_m1 = 0; e_last = 0; left = 0;
        end else if (e_busy) begin
            left--;
            if (left == 0) begin e_busy = 0; e_done = 1; end
        end else begin
            e_done = 0;
            if (start) begin
                resolve(src, dst, mask_s0, mask_mid, mask_last, hv, s0, mi0, mi1, la, drop, lat);
                e_hv = hv; e_s0 = s0; e_m0 = mi0; e_m1 = mi1; e_last = la; e_drop = drop;
                e_busy = 1; left = lat;
            end
        end
    end

    // compare on each falling edge
    always @(negedge clk) begin
        if (seen) begin
            check("R8", "busy", busy, e_busy);
            check("R7", "done", done, e_done);
            if (!e_busy) begin
                check(cur_req, "dropped", dropped, e_drop);
                check(cur_req, "hop_valid", hop_valid, e_hv);
                check(cur_req, "sel_s0", sel_s0, e_s0);
                check(cur_req, "sel_mid", sel_mid, e_m1*4 + e_m0);
                check(cur_req, "sel_last", sel_last, e_last);
            end
        end
    end

    // one request; masks are scrambled after capture to prove they were latched
    task automatic run(input string req, input int s, input int d,
                       input int a0, input int am, input int al);
        cur_req = req;
        @(negedge clk);
        src = 4'(s); dst = 4'(d);
        mask_s0 = 8'(a0); mask_mid = 8'(am); mask_last = 8'(al);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mask_s0 = '1; mask_mid = '1; mask_last = '1;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state seen at the ports
        check("R10", "busy", busy, 0);
        check("R10", "done", done, 0);
        check("R10", "hop_valid", hop_valid, 0);
        check("R10", "sel_last", sel_last, 0);
        rst_n = 1'b1;

        // R1: clear maps, several port pairs in both halves
        run("R1", 1, 6, 0, 0, 0);
        run("R1", 2, 9, 0, 0, 0);
        run("R1", 7, 12, 0, 0, 0);
        // R2: fallbacks through the stage-0 order, then all four masked
        run("R2", 1, 6, 8'h02, 0, 0);
        run("R2", 1, 6, 8'h0A, 0, 0);
        run("R2", 1, 6, 8'h2A, 0, 0);
        run("R2", 1, 6, 8'hAA, 0, 0);
        run("R2", 0, 12, 8'h10, 0, 0);
        // R3: bypass taken, refused by the final map, refused by the stage-0 map
        run("R3", 5, 5, 0, 0, 0);
        run("R3", 12, 12, 0, 0, 0);
        run("R3", 5, 5, 0, 0, 8'h02);
        run("R3", 5, 5, 8'h02, 0, 0);
        // R4: first middle stage alternate and drop
        run("R4", 1, 6, 0, 8'h01, 0);
        run("R4", 1, 6, 0, 8'h03, 0);
        // R5: second middle stage alternate and drop
        run("R5", 2, 0, 0, 8'h10, 0);
        run("R5", 2, 0, 0, 8'h30, 0);
        // R6: final stage drop, even and odd middle switches
        run("R6", 1, 6, 0, 0, 8'h02);
        run("R6", 2, 9, 0, 0, 8'h40);
        // R8: a start pulse while busy is ignored
        cur_req = "R8";
        @(negedge clk);
        src = 4'd3; dst = 4'd10; mask_s0 = '0; mask_mid = '0; mask_last = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        src = 4'd0; dst = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        // R8 / R9: start held high, so the next request is taken in the done cycle
        cur_req = "R9";
        src = 4'd6; dst = 4'd1; start = 1'b1;
        repeat (9) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        // R2: sparse random maps across all port pairs
        for (int n = 0; n < 300; n++) begin
            run("R2", int'($urandom_range(15)), int'($urandom_range(15)),
                int'($urandom & $urandom & 8'hFF), int'($urandom & $urandom & 8'hFF),
                int'($urandom & $urandom & $urandom & 8'hFF));
        end
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule